// File: doc/BRIEF.md
# Variable-Length Trace Message Encoder

This block turns one filtered load-trace record into a compact bit string for a narrow trace port. A record holds four fields: a differential cycle count, the number of the core that made the load, a count of first-access hits, and the loaded value. The two counters are long and usually small, so each is cut into chunks. The least significant chunk goes first, and a continuation bit follows every chunk. Chunks stop as soon as the remaining high bits are all zero. The core number and the load value go out at fixed widths.

Two chunking modes exist. The baseline mode uses 8-bit chunks for both counters. The enhanced mode uses a 4-bit first chunk and 2-bit later chunks for the cycle count, and 2-bit chunks throughout for the hit count. A record enters over a valid/ready handshake, and the mode pin is sampled in the same cycle. The encoded string then leaves as 8-bit words over a second valid/ready handshake, least significant bit first. Back-pressure works as follows. The input side stays not-ready from the accepting edge until the last word of the record has been taken. The output side holds each word steady until the sink takes it.

Top module: `trace_msg_vlenc`

## Requirements
- R1: The encoded bits are ordered cycle-count field, core number, hit-count field, load value. They are packed least significant bit first, so encoded bit k appears in output word k/8 at bit position k%8.
- R2: With in_enh = 0, each counter is sent as 8-bit chunks, least significant chunk first, with its bits least significant first. Each chunk is followed by one continuation bit: 1 means another chunk of the same field follows, and 0 ends the field.
- R3: With in_enh = 1, the cycle-count field uses a 4-bit first chunk and 2-bit later chunks, with the same continuation rule.
- R4: With in_enh = 1, the hit-count field uses 2-bit chunks for the first chunk and for every later chunk.
- R5: A counter of value zero still sends exactly one chunk, with continuation bit 0. Beyond that, no chunk is sent once the remaining high-order bits are all zero.
- R6: The core number is sent as ceil(log2 NUM_CORES) bits (2 bits by default), and the load value as 32 bits, both least significant bit first.
- R7: The record produces ceil(length/8) words. Bits of the final word beyond the record's length are 0, and out_last is 1 only on that final word.
- R8: in_ready is 0 from the cycle after an accept until the final word is taken. In the cycle after that handshake, in_ready is 1 and out_valid is 0.
- R9: While out_valid is 1 and out_ready is 0, out_word, out_last and out_valid hold their values at the next edge.
- R10: in_enh is sampled only when a record is accepted. Changing it while the record is being sent has no effect on that record's words.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A record is offered |
| in_ready | output | 1 | The encoder can take a record |
| in_enh | input | 1 | 0 selects baseline chunking, 1 selects enhanced chunking |
| in_dcyc | input | CYC_W (16) | Differential cycle count |
| in_core | input | CORE_W (2) | Core number |
| in_hits | input | HIT_W (16) | First-access hit count |
| in_value | input | VAL_W (32) | Load value |
| out_valid | output | 1 | out_word holds a word of the record |
| out_ready | input | 1 | The sink takes the word at this edge |
| out_word | output | OUT_W (8) | Packed encoded bits |
| out_last | output | 1 | This word is the final word of the record |

## Verification
A record is accepted at the rising edge where in_valid and in_ready are both high. Its first word is on out_word from the following cycle. Each later word appears one cycle after the handshake that took the previous word. in_ready rises in the cycle after the handshake on the final word. The bench drives the ports and samples them on falling edges, so every expected value is compared half a cycle after the edge that produced it. The bench model builds the expected bit string from the requirements. It then compares the words in order, the word count, the placement of out_last, the holding of each word under a stalled sink, and the handshake state after each record.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;
  typedef enum logic {
    CHUNK_BASE = 1'b0,
    CHUNK_ENH  = 1'b1
  } chunk_mode_e;

  // upper bound of an encoded counter field: data bits rounded up to a
  // whole chunk plus one continuation bit per chunk (chunk size >= 1)
  function automatic int field_max(input int w);
    return 2 * w + 8;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/vlenc_chunker.sv
module vlenc_chunker
  import trace_enc_pkg::*;
#(
  parameter int W         = 16,
  parameter int BASE_SZ   = 8,
  parameter int ENH_FIRST = 4,
  parameter int ENH_NEXT  = 2,
  localparam int FLD_MAX  = field_max(W),
  localparam int LEN_W    = $clog2(FLD_MAX + 1)
) (
  input  chunk_mode_e        mode,
  input  logic [W-1:0]       value,
  output logic [FLD_MAX-1:0] bits,
  output logic [LEN_W-1:0]   len
);
  localparam int MAX_SZ = max3(BASE_SZ, ENH_FIRST, ENH_NEXT);

  logic [W-1:0]     rem;
  logic [LEN_W-1:0] pos;
  logic             stop;
  logic             more;
  int               sz;

  always_comb begin
    bits = '0;
    rem  = value;
    pos  = '0;
    stop = 1'b0;
    more = 1'b0;
    sz   = BASE_SZ;
    for (int k = 0; k < W; k++) begin
      if (!stop) begin
        if (mode == CHUNK_ENH) sz = (k == 0) ? ENH_FIRST : ENH_NEXT;
        else                   sz = BASE_SZ;
        for (int j = 0; j < MAX_SZ; j++) begin
          if (j < sz) begin
            bits[pos] = rem[0];
            rem       = rem >> 1;
            pos       = pos + 1'b1;
          end
        end
        more      = |rem;
        bits[pos] = more;
        pos       = pos + 1'b1;
        stop      = !more;
      end
    end
    len = pos;
  end
endmodule

// File: rtl/vlenc_assembler.sv
module vlenc_assembler
  import trace_enc_pkg::*;
#(
  parameter int CYC_W   = 16,
  parameter int HIT_W   = 16,
  parameter int CORE_W  = 2,
  parameter int VAL_W   = 32,
  localparam int CF_MAX = field_max(CYC_W),
  localparam int HF_MAX = field_max(HIT_W),
  localparam int CL_W   = $clog2(CF_MAX + 1),
  localparam int HL_W   = $clog2(HF_MAX + 1),
  localparam int MSG_MAX = CF_MAX + CORE_W + HF_MAX + VAL_W,
  localparam int MLEN_W  = $clog2(MSG_MAX + 1)
) (
  input  logic [CF_MAX-1:0]  cyc_bits,
  input  logic [CL_W-1:0]    cyc_len,
  input  logic [CORE_W-1:0]  core,
  input  logic [HF_MAX-1:0]  hit_bits,
  input  logic [HL_W-1:0]    hit_len,
  input  logic [VAL_W-1:0]   value,
  output logic [MSG_MAX-1:0] msg,
  output logic [MLEN_W-1:0]  msg_len
);
  logic [MLEN_W-1:0] off_core, off_hit, off_val;

  always_comb begin
    off_core = MLEN_W'(cyc_len);
    off_hit  = off_core + MLEN_W'(CORE_W);
    off_val  = off_hit + MLEN_W'(hit_len);
    msg_len  = off_val + MLEN_W'(VAL_W);
    msg = MSG_MAX'(cyc_bits)
        | (MSG_MAX'(core)     << off_core)
        | (MSG_MAX'(hit_bits) << off_hit)
        | (MSG_MAX'(value)    << off_val);
  end
endmodule

// File: rtl/vlenc_packer.sv
module vlenc_packer #(
  parameter int MSG_MAX = 114,
  parameter int OUT_W   = 8,
  localparam int MLEN_W = $clog2(MSG_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [MSG_MAX-1:0] msg,
  input  logic [MLEN_W-1:0]  msg_len,
  output logic               busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_word,
  output logic               out_last
);
  logic [MSG_MAX-1:0] shreg;
  logic [MLEN_W-1:0]  left;

  assign busy      = (left != '0);
  assign out_valid = busy;
  assign out_word  = shreg[OUT_W-1:0];
  assign out_last  = busy && (left <= MLEN_W'(OUT_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= msg;
      left  <= msg_len;
    end else if (out_valid && out_ready) begin
      shreg <= shreg >> OUT_W;
      left  <= out_last ? '0 : left - MLEN_W'(OUT_W);
    end
  end
endmodule

// File: rtl/trace_msg_vlenc.sv
module trace_msg_vlenc
  import trace_enc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CYC_W     = 16,
  parameter int HIT_W     = 16,
  parameter int VAL_W     = 32,
  parameter int OUT_W     = 8,
  parameter int BASE_SZ   = 8,
  parameter int CYC_FIRST = 4,
  parameter int CYC_NEXT  = 2,
  parameter int HIT_FIRST = 2,
  parameter int HIT_NEXT  = 2,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_enh,
  input  logic [CYC_W-1:0]  in_dcyc,
  input  logic [CORE_W-1:0] in_core,
  input  logic [HIT_W-1:0]  in_hits,
  input  logic [VAL_W-1:0]  in_value,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_word,
  output logic              out_last
);
  localparam int CF_MAX  = field_max(CYC_W);
  localparam int HF_MAX  = field_max(HIT_W);
  localparam int CL_W    = $clog2(CF_MAX + 1);
  localparam int HL_W    = $clog2(HF_MAX + 1);
  localparam int MSG_MAX = CF_MAX + CORE_W + HF_MAX + VAL_W;
  localparam int MLEN_W  = $clog2(MSG_MAX + 1);

  chunk_mode_e        mode;
  logic [CF_MAX-1:0]  cyc_bits;
  logic [CL_W-1:0]    cyc_len;
  logic [HF_MAX-1:0]  hit_bits;
  logic [HL_W-1:0]    hit_len;
  logic [MSG_MAX-1:0] msg;
  logic [MLEN_W-1:0]  msg_len;
  logic               busy;
  logic               accept;

  assign mode     = in_enh ? CHUNK_ENH : CHUNK_BASE;
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  vlenc_chunker #(
    .W(CYC_W), .BASE_SZ(BASE_SZ), .ENH_FIRST(CYC_FIRST), .ENH_NEXT(CYC_NEXT)
  ) u_cyc (
    .mode(mode), .value(in_dcyc), .bits(cyc_bits), .len(cyc_len)
  );

  vlenc_chunker #(
    .W(HIT_W), .BASE_SZ(BASE_SZ), .ENH_FIRST(HIT_FIRST), .ENH_NEXT(HIT_NEXT)
  ) u_hit (
    .mode(mode), .value(in_hits), .bits(hit_bits), .len(hit_len)
  );

  vlenc_assembler #(
    .CYC_W(CYC_W), .HIT_W(HIT_W), .CORE_W(CORE_W), .VAL_W(VAL_W)
  ) u_asm (
    .cyc_bits(cyc_bits), .cyc_len(cyc_len), .core(in_core),
    .hit_bits(hit_bits), .hit_len(hit_len), .value(in_value),
    .msg(msg), .msg_len(msg_len)
  );

  vlenc_packer #(
    .MSG_MAX(MSG_MAX), .OUT_W(OUT_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n), .load(accept), .msg(msg), .msg_len(msg_len),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_last(out_last)
  );
endmodule

// File: rtl/trace_msg_vlenc_chk.sv
module trace_msg_vlenc_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_word,
  input logic             out_last
);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));

  // R8
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready));

  // R8
  last_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

  // R7
  mid_word_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_valid);
endmodule

bind trace_msg_vlenc trace_msg_vlenc_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
  .out_last(out_last)
);

// File: tb/trace_msg_vlenc_test.sv
`timescale 1ns/1ps
module trace_msg_vlenc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_enh = 1'b0;
  logic [15:0] in_dcyc = '0;
  logic [1:0]  in_core = '0;
  logic [15:0] in_hits = '0;
  logic [31:0] in_value = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_word;
  logic        out_last;

  int total = 0;
  int bad = 0;

  logic exp_bits [0:255];
  int   exp_len;
  logic [7:0] got [0:31];
  logic       got_last [0:31];
  int         got_n;

  always #2 clk = ~clk;

  trace_msg_vlenc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_enh(in_enh), .in_dcyc(in_dcyc), .in_core(in_core), .in_hits(in_hits),
    .in_value(in_value), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic b);
    exp_bits[exp_len] = b;
    exp_len++;
  endtask

  task automatic put_counter(input logic [15:0] v, input int first, input int next);
    int sz = first;
    logic [15:0] r = v;
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < sz; i++) begin
        put(r[0]);
        r = r >> 1;
      end
      put(r != 0);
      if (r == 0) break;
      sz = next;
    end
  endtask

  // expected string from R1..R6
  task automatic model(input bit enh, input logic [15:0] cyc, input logic [1:0] core,
                       input logic [15:0] hits, input logic [31:0] val);
    exp_len = 0;
    put_counter(cyc, enh ? 4 : 8, enh ? 2 : 8);
    for (int i = 0; i < 2; i++) put(core[i]);
    put_counter(hits, enh ? 2 : 8, enh ? 2 : 8);
    for (int i = 0; i < 32; i++) put(val[i]);
  endtask

  // drive one record, collect words; ready_gap>0 stalls the sink on every ready_gap-th cycle
  task automatic run_msg(input bit enh, input logic [15:0] cyc, input logic [1:0] core,
                         input logic [15:0] hits, input logic [31:0] val,
                         input int ready_gap, input bit flip_mode, input string req);
    int cyc_cnt = 0;
    bit stalled = 0;
    logic [7:0] held = '0;
    bit rdy_ok = 1;
    model(enh, cyc, core, hits, val);
    @(negedge clk);
    in_valid = 1'b1; in_enh = enh; in_dcyc = cyc; in_core = core;
    in_hits = hits; in_value = val;
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; in_dcyc = ~cyc; in_hits = ~hits; in_value = ~val;
    if (flip_mode) in_enh = ~enh;
    got_n = 0;
    forever begin
      if (stalled) check(out_word == held && out_valid, "R9 word held under stall", out_word, held);
      if (out_valid && in_ready) rdy_ok = 0;
      out_ready = (ready_gap > 0) ? ((cyc_cnt % ready_gap) != 0) : 1'b1;
      stalled = out_valid && !out_ready;
      held = out_word;
      if (out_valid && out_ready) begin
        got[got_n] = out_word;
        got_last[got_n] = out_last;
        got_n++;
        if (out_last) break;
      end
      cyc_cnt++;
      if (cyc_cnt > 300) begin
        check(0, "R7 record never ended", got_n, -1);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(rdy_ok, "R8 in_ready low while sending", 0, 1);
    check(in_ready && !out_valid, "R8 idle after final word", {in_ready, out_valid}, 2'b10);
    check(got_n == (exp_len + 7) / 8, {req, " / R7 word count"}, got_n, (exp_len + 7) / 8);
    for (int w = 0; w < got_n; w++) begin
      logic [7:0] e = '0;
      for (int b = 0; b < 8; b++)
        e[b] = (w * 8 + b < exp_len) ? exp_bits[w * 8 + b] : 1'b0;
      check(got[w] == e, {req, " / R1 word content"}, got[w], e);
      check(got_last[w] == (w == got_n - 1), "R7 out_last placement", got_last[w], w == got_n - 1);
    end
  endtask

  task automatic t_reset();
    check(!out_valid && in_ready, "R11 during reset", {out_valid, in_ready}, 2'b01);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R11 after reset", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_baseline();
    run_msg(0, 16'h0123, 2'd1, 16'h0000, 32'hA5A5_A5C3, 0, 0, "R2 two-chunk cycle count");
    run_msg(0, 16'h00FF, 2'd3, 16'hBEEF, 32'h1234_5678, 0, 0, "R2 R6 full hit count");
    run_msg(0, 16'hFFFF, 2'd2, 16'h0100, 32'hFFFF_0001, 0, 0, "R2 R1 all ones");
  endtask

  task automatic t_enhanced();
    run_msg(1, 16'h000F, 2'd2, 16'h0003, 32'h8000_0001, 0, 0, "R3 R4 single chunks");
    run_msg(1, 16'h0010, 2'd1, 16'h0004, 32'h0F0F_0F0F, 0, 0, "R3 R4 second chunk");
    run_msg(1, 16'hFFFF, 2'd3, 16'hFFFF, 32'hDEAD_BEEF, 0, 0, "R3 R4 longest fields");
  endtask

  task automatic t_zero();
    run_msg(0, 16'h0000, 2'd0, 16'h0000, 32'h0000_0000, 0, 0, "R5 zero baseline");
    check(got_n == 7, "R5 zero baseline is 52 bits", got_n, 7);
    run_msg(1, 16'h0000, 2'd0, 16'h0000, 32'h0000_0000, 0, 0, "R5 zero enhanced");
    check(got_n == 6, "R5 zero enhanced is 42 bits", got_n, 6);
  endtask

  task automatic t_backpressure();
    run_msg(0, 16'h4321, 2'd1, 16'h0077, 32'hCAFE_F00D, 2, 0, "R9 alternate stall");
    run_msg(1, 16'h0ABC, 2'd2, 16'h0155, 32'h0BAD_CAFE, 3, 0, "R9 every third stall");
  endtask

  task automatic t_mode_sample();
    run_msg(1, 16'h0321, 2'd3, 16'h0022, 32'h7654_3210, 0, 1, "R10 enh kept after pin change");
    run_msg(0, 16'h0321, 2'd3, 16'h0022, 32'h7654_3210, 0, 1, "R10 base kept after pin change");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_baseline();
    t_enhanced();
    t_zero();
    t_backpressure();
    t_mode_sample();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule